// File: doc/BRIEF.md
# Instruction Length Decoder

The block takes one 16-bit opcode word, marked by an input strobe, and works out how many 16-bit extension words the fetch unit must pull in after it before the instruction is complete. It recognises three instruction groups: the two-operand move with separate source and destination addressing fields, the add family (including the address-register add forms), and the conditional branch. It reports the group, the operand size, the extension count for each side, the total length in words, and a flag for addressing combinations that cannot be encoded.

Each addressing field is a 3-bit mode plus a 3-bit register value. That register value picks a subclass only when the mode is 7. Decoding is combinational. The results go through one register stage, and a two-state machine drives the output valid flag one cycle after each strobe. The fetch unit uses the total length to step its word pointer to the next opcode.

Top module: `instr_len_decoder`

States: `ST_IDLE` (nothing to show) and `ST_SHOW` (a result is on the outputs). Transitions: `ST_IDLE`→`ST_SHOW` on a strobe, `ST_SHOW`→`ST_SHOW` on a strobe, `ST_SHOW`→`ST_IDLE` when there is no strobe. Reset enters `ST_IDLE`.

## Requirements
- R1: `out_valid` is high in the cycle after each clock edge at which `in_valid` was high, and low otherwise. Reset drives `out_valid` and every result field to zero.
- R2: Group code on `out_class`:
  - 1 when opcode bits 15:14 are 00.
  - 2 when bits 15:12 are 1101.
  - 3 when bits 15:12 are 0110.
  - 0 for any other opcode.
- R3: For the move group, size bits 13:12 map to `out_size` as follows: 01 gives 0 (byte), 11 gives 1 (word), 10 gives 2 (long). Code 00 gives 3 (none) and raises `out_illegal`.
- R4: Addressing modes 0 to 4 need no extension word. Modes 5 and 6 need one.
- R5: Mode 7 subclasses need these extension counts:
  - 000 (absolute short): 1.
  - 001 (absolute long): 2.
  - 010 and 011 (program-counter relative): 1.
  - Any subclass above 100: count 0, and `out_illegal` is raised.
- R6: Subclass 100 (immediate) needs two words when the operand size is long, and one word for every other size.
- R7: For the move group, the source field is bits 5:3 (mode) and 2:0 (register). The destination field is bits 8:6 (mode) and 11:9 (register). A destination of mode 7 with subclass 010, 011 or 100 raises `out_illegal`, and its count from R5/R6 still applies.
- R8: For the add group, bits 8:6 select the form:
  - 000, 001, 010: byte, word, long, with the EA (bits 5:0) as source.
  - 100, 101, 110: byte, word, long, with the EA as destination, so the destination rule of R7 applies.
  - 011 and 111: word and long address-register add, with the EA as source.
  - The side that is not the EA counts 0.
- R9: For the branch group, a zero displacement (bits 7:0) gives a source count of 1. Any other displacement gives 0. The destination count is 0 and `out_size` is 3.
- R10: `out_len` equals 1 plus `out_src_ext` plus `out_dst_ext`.
- R11: Any other opcode gives size 3, both counts 0, length 1 and no illegal flag.
- R12: When no strobe arrives, all result fields keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Opcode strobe |
| in_opcode | input | 16 | Opcode word |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| out_class | output | 2 | Group code |
| out_size | output | 2 | Operand size code |
| out_src_ext | output | 2 | Source extension word count |
| out_dst_ext | output | 2 | Destination extension word count |
| out_len | output | 3 | Total length in words |
| out_illegal | output | 1 | Unencodable combination flag |

## Verification
A fault in the state register shows up as `out_valid` being wrong in the very next cycle. Examples are a stuck `ST_SHOW` or a missed transition back to `ST_IDLE`. A wrong subclass count, a swapped move field, or an add form routed to the wrong side shows up in the result fields in the cycle after that opcode's strobe. A result register that loads without a strobe breaks the hold rule at the next unstrobed cycle. The reference model is compared in every cycle, so each of these faults is caught within one cycle of its cause.

// File: rtl/ild_pkg.sv
package ild_pkg;
    localparam int OP_W   = 16;
    localparam int MODE_W = 3;
    localparam int EXT_W  = 2;
    localparam int LEN_W  = 3;
    localparam int SIDES  = 2;

    typedef enum logic [1:0] {
        GRP_OTHER  = 2'd0,
        GRP_MOVE   = 2'd1,
        GRP_ADD    = 2'd2,
        GRP_BRANCH = 2'd3
    } grp_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_NONE = 2'd3
    } sz_t;

    typedef struct packed {
        grp_t              grp;
        sz_t               sz;
        logic [EXT_W-1:0]  src_ext;
        logic [EXT_W-1:0]  dst_ext;
        logic [LEN_W-1:0]  len;
        logic              bad;
    } result_t;
endpackage

// File: rtl/ild_ea_count.sv
module ild_ea_count
    import ild_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    input  logic [MODE_W-1:0] sub,
    input  sz_t               sz,
    input  logic              is_dst,
    input  logic              used,
    output logic [EXT_W-1:0]  ext,
    output logic              bad
);
    logic [EXT_W-1:0] raw_ext;
    logic             raw_bad;

    always_comb begin
        raw_ext = '0;
        raw_bad = 1'b0;
        unique case (mode)
            3'd5, 3'd6: raw_ext = 2'd1;
            3'd7: begin
                unique case (sub)
                    3'd0:       raw_ext = 2'd1;
                    3'd1:       raw_ext = 2'd2;
                    3'd2, 3'd3: raw_ext = 2'd1;
                    3'd4:       raw_ext = (sz == SZ_LONG) ? 2'd2 : 2'd1;
                    default:    raw_bad = 1'b1;
                endcase
                if (is_dst && (sub == 3'd2 || sub == 3'd3 || sub == 3'd4))
                    raw_bad = 1'b1;
            end
            default: raw_ext = '0;
        endcase
    end

    assign ext = used ? raw_ext : '0;
    assign bad = used & raw_bad;

    always_comb begin
        if (used && mode < 3'd5)
            AST_LOW_MODES_NO_EXT: assert (ext == '0); // R4
    end
endmodule

// File: rtl/ild_classify.sv
module ild_classify
    import ild_pkg::*;
(
    input  logic [OP_W-1:0]          op,
    output grp_t                     grp,
    output sz_t                      sz,
    output logic [SIDES-1:0][MODE_W-1:0] ea_mode,
    output logic [SIDES-1:0][MODE_W-1:0] ea_sub,
    output logic [SIDES-1:0]         ea_used,
    output logic [EXT_W-1:0]         br_ext,
    output logic                     sz_bad
);
    // side 0 = source, side 1 = destination
    always_comb begin
        grp     = GRP_OTHER;
        sz      = SZ_NONE;
        ea_mode = '0;
        ea_sub  = '0;
        ea_used = '0;
        br_ext  = '0;
        sz_bad  = 1'b0;
        if (op[15:14] == 2'b00) begin
            grp = GRP_MOVE;
            unique case (op[13:12])
                2'b01:   sz = SZ_BYTE;
                2'b11:   sz = SZ_WORD;
                2'b10:   sz = SZ_LONG;
                default: begin sz = SZ_NONE; sz_bad = 1'b1; end
            endcase
            ea_mode[0] = op[5:3];
            ea_sub[0]  = op[2:0];
            ea_mode[1] = op[8:6];
            ea_sub[1]  = op[11:9];
            ea_used    = 2'b11;
        end else if (op[15:12] == 4'b1101) begin
            grp = GRP_ADD;
            unique case (op[8:6])
                3'b000, 3'b100: sz = SZ_BYTE;
                3'b001, 3'b101, 3'b011: sz = SZ_WORD;
                default: sz = SZ_LONG;
            endcase
            if (op[8] && op[7:6] != 2'b11) begin
                ea_mode[1] = op[5:3];
                ea_sub[1]  = op[2:0];
                ea_used    = 2'b10;
            end else begin
                ea_mode[0] = op[5:3];
                ea_sub[0]  = op[2:0];
                ea_used    = 2'b01;
            end
        end else if (op[15:12] == 4'b0110) begin
            grp    = GRP_BRANCH;
            br_ext = (op[7:0] == 8'h00) ? 2'd1 : 2'd0;
        end
    end
endmodule

// File: rtl/instr_len_decoder.sv
module instr_len_decoder
    import ild_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [15:0] in_opcode,
    output logic        out_valid,
    output logic [1:0]  out_class,
    output logic [1:0]  out_size,
    output logic [1:0]  out_src_ext,
    output logic [1:0]  out_dst_ext,
    output logic [2:0]  out_len,
    output logic        out_illegal
);
    typedef enum logic {ST_IDLE, ST_SHOW} state_t;

    state_t state_q, state_d;
    grp_t   grp;
    sz_t    sz;
    logic [SIDES-1:0][MODE_W-1:0] ea_mode, ea_sub;
    logic [SIDES-1:0]             ea_used, ea_bad;
    logic [SIDES-1:0][EXT_W-1:0]  ea_ext;
    logic [EXT_W-1:0]             br_ext;
    logic                         sz_bad;
    result_t                      res_d, res_q;

    ild_classify u_cls (
        .op      (in_opcode),
        .grp     (grp),
        .sz      (sz),
        .ea_mode (ea_mode),
        .ea_sub  (ea_sub),
        .ea_used (ea_used),
        .br_ext  (br_ext),
        .sz_bad  (sz_bad)
    );

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        ild_ea_count u_cnt (
            .mode   (ea_mode[g]),
            .sub    (ea_sub[g]),
            .sz     (sz),
            .is_dst (g == 1),
            .used   (ea_used[g]),
            .ext    (ea_ext[g]),
            .bad    (ea_bad[g])
        );
    end

    always_comb begin
        res_d.grp     = grp;
        res_d.sz      = sz;
        res_d.src_ext = ea_ext[0] | br_ext;
        res_d.dst_ext = ea_ext[1];
        res_d.len     = LEN_W'(1) + LEN_W'(res_d.src_ext) + LEN_W'(res_d.dst_ext);
        res_d.bad     = sz_bad | (|ea_bad);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid)  state_d = ST_SHOW;
            ST_SHOW: if (!in_valid) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
        out_valid = (state_q == ST_SHOW);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        res_q <= '0;
        else if (in_valid) res_q <= res_d;
    end

    assign out_class   = res_q.grp;
    assign out_size    = res_q.sz;
    assign out_src_ext = res_q.src_ext;
    assign out_dst_ext = res_q.dst_ext;
    assign out_len     = res_q.len;
    assign out_illegal = res_q.bad;

    AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_LEN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len == 3'd1 + 3'(out_src_ext) + 3'(out_dst_ext)); // R10
    AST_BRANCH_NO_DST: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_class == 2'd3) |-> (out_dst_ext == 2'd0 && out_size == 2'd3)); // R9
    AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_len) && $stable(out_class) && $stable(out_illegal))); // R12
endmodule

// File: tb/instr_len_decoder_tb_top.sv
module instr_len_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_opcode = 16'h0;
    logic        out_valid;
    logic [1:0]  out_class, out_size, out_src_ext, out_dst_ext;
    logic [2:0]  out_len;
    logic        out_illegal;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    int  m_valid = 0, m_cls = 0, m_sz = 0, m_se = 0, m_de = 0, m_len = 0, m_ill = 0;

    always #5 clk = ~clk;

    instr_len_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
        .out_valid(out_valid), .out_class(out_class), .out_size(out_size),
        .out_src_ext(out_src_ext), .out_dst_ext(out_dst_ext),
        .out_len(out_len), .out_illegal(out_illegal)
    );

    function automatic int ea_words(int mode, int sub, int size, bit dst, ref int ill);
        if (mode <= 4) return 0;
        if (mode == 5 || mode == 6) return 1;
        if (dst && (sub == 2 || sub == 3 || sub == 4)) ill = 1;
        if (sub == 1) return 2;
        if (sub == 4) return (size == 2) ? 2 : 1;
        if (sub <= 3) return 1;
        ill = 1;
        return 0;
    endfunction

    task automatic model(input logic [15:0] op);
        int top4 = int'(op[15:12]);
        int ea_m = int'(op[5:3]);
        int ea_r = int'(op[2:0]);
        int ill = 0;
        int cls = 0, sz = 3, se = 0, de = 0;
        if (op[15:14] == 2'b00) begin
            cls = 1;
            case (int'(op[13:12]))
                1: sz = 0;
                3: sz = 1;
                2: sz = 2;
                default: begin sz = 3; ill = 1; end
            endcase
            se = ea_words(ea_m, ea_r, sz, 0, ill);
            de = ea_words(int'(op[8:6]), int'(op[11:9]), sz, 1, ill);
        end else if (top4 == 13) begin
            int om = int'(op[8:6]);
            cls = 2;
            if (om == 0 || om == 4) sz = 0;
            else if (om == 1 || om == 5 || om == 3) sz = 1;
            else sz = 2;
            if (om == 4 || om == 5 || om == 6) de = ea_words(ea_m, ea_r, sz, 1, ill);
            else se = ea_words(ea_m, ea_r, sz, 0, ill);
        end else if (top4 == 6) begin
            cls = 3;
            se = (op[7:0] == 0) ? 1 : 0;
        end
        m_cls = cls; m_sz = sz; m_se = se; m_de = de; m_len = 1 + se + de; m_ill = ill;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 0;
            m_cls = 0; m_sz = 0; m_se = 0; m_de = 0; m_len = 0; m_ill = 0;
        end else begin
            m_valid <= int'(in_valid);
            if (in_valid) model(in_opcode);
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s op=%h actual=%0d expected=%0d at %0t", tag, in_opcode, act, exp, $time);
        end
    endtask

    // compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 valid", int'(out_valid), m_valid);
            check("R2 class", int'(out_class), m_cls);
            check("R3/R8 size", int'(out_size), m_sz);
            check("R4/R5/R6/R7/R9 src_ext", int'(out_src_ext), m_se);
            check("R4/R5/R6/R7/R8 dst_ext", int'(out_dst_ext), m_de);
            check("R10/R11/R12 len", int'(out_len), m_len);
            check("R3/R5/R7 illegal", int'(out_illegal), m_ill);
        end
    end

    task automatic send(input logic [15:0] op);
        @(negedge clk);
        #1;
        in_valid = 1'b1;
        in_opcode = op;
        @(negedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] dir [$] = '{16'h3200, 16'h323C, 16'h223C, 16'h13F9, 16'h19C0,
                                 16'h0000, 16'h303D, 16'hD040, 16'hD0BC, 16'hD1FC,
                                 16'hD179, 16'h6600, 16'h66FE, 16'h4E75, 16'h3028,
                                 16'h2170, 16'h3038, 16'h303B, 16'hD13C};
        repeat (3) @(negedge clk);
        // reset state (R1)
        check("R1 reset valid", int'(out_valid), 0);
        check("R1 reset len", int'(out_len), 0);
        rst_n = 1'b1;
        foreach (dir[i]) send(dir[i]);
        // back-to-back strobes
        @(negedge clk); #1;
        in_valid = 1'b1;
        for (int i = 0; i < 16; i++) begin
            in_opcode = 16'h0101 * 16'(i) ^ 16'h3C3C;
            @(negedge clk); #1;
        end
        in_valid = 1'b0;
        // random traffic with gaps and opcode changes while idle (R12)
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            in_valid  = ($urandom_range(0, 2) != 0);
            in_opcode = 16'($urandom());
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule